// File: doc/BRIEF.md
# Compare-Triggered Interval Timer Channel

This block is one 16-bit interval timer channel. It advances on each cycle where an upstream prescaler raises a count-enable pulse. A restart can come from a software strobe, a broadcast sync line, a match against a programmable period value C, or an asynchronous external event. A restart request does not clear the counter at once. It is held pending, and the counter lands on zero at the next accepted count pulse. With the compare restart enabled, the channel produces a periodic interval of C+1 count pulses.

Three events latch into sticky status flags: counter wrap, reaching C, and an accepted external event. A level interrupt is raised while any flag whose enable bit is set is high. Software drives the channel through a small register port. That port offers run/stop/restart commands, a write-one-to-set and write-one-to-clear pair for the interrupt enables, a status register that clears when read, and readback of the mode, the period and the live count.

Top module: `ivl_timer_chan`

Register map (regAddr):
- 0: command, write only. Bit 0 starts the channel, bit 1 stops it, bit 2 requests a restart.
- 1: mode, read/write. Bit 0 selects the compare restart, bit 1 accepts the external event.
- 2: period C, read/write.
- 3: status, read clears.
- 4: interrupt-enable set.
- 5: interrupt-enable clear.
- 6: interrupt enables, read only.
- 7: live count, read only.

## Requirements
- R1: After reset the count reads 0, status and interrupt enables read 0, irq is low, and the channel is stopped, so count pulses do not change the count.
- R2: Writing 1 to bit 0 of address 0 starts the channel. While it runs, each cycle with cntTick high adds one to the count at address 7.
- R3: When bits 0 and 1 of address 0 are written together, the channel stops. While the channel is stopped, count pulses and restart requests are ignored, and a pending restart is dropped.
- R4: A restart from bit 2 of address 0, or from syncIn held high for a cycle, leaves the count unchanged until the next count pulse, which loads 0.
- R5: A count pulse that takes the count from 0xFFFF to 0x0000 sets status bit 0.
- R6: A count pulse that brings the count to the value at address 2 sets status bit 4. This holds whatever the mode. With mode bit 0 set, the count equal to C acts as a restart, so the count cycles through 0..C.
- R7: With mode bit 1 set, a rising edge on extTrigIn acts as a restart and sets status bit 7. It passes a two-flop synchronizer and an edge detector first. With mode bit 1 clear, the edge has no effect.
- R8: Writing ones to address 4 sets interrupt-enable bits, and writing ones to address 5 clears them. Only bits 0, 4 and 7 exist, and address 6 reads the result.
- R9: irq is high exactly when some status bit and its interrupt-enable bit are both set.
- R10: Reading address 3 returns the flags and clears them. A flag whose event occurs in that same cycle stays set.
- R11: Addresses 1 and 2 read back the last mode and period written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntTick | input | 1 | Count-enable pulse from the selected prescaler |
| syncIn | input | 1 | Broadcast restart request |
| extTrigIn | input | 1 | Asynchronous external event |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data, valid in the cycle of regRd |
| irq | output | 1 | Level interrupt |

## Verification
The bench goes after the deferred restart, reading the count between the restart and the next pulse. A design that cleared the count at once would read 0 instead of the held value. It checks a simultaneous start and stop, and a restart issued while stopped. A wrong priority would let the count move, or would let a stale restart zero it later. It runs a full wrap from 0xFFFF and a compare period. It also lands a compare hit in the very cycle that status is read, so a clear that overrode fresh events would lose that flag. Last, it sends an external edge with the accept bit clear, which must leave the count running on.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

  localparam logic [2:0] A_CMD   = 3'd0;
  localparam logic [2:0] A_MODE  = 3'd1;
  localparam logic [2:0] A_PER   = 3'd2;
  localparam logic [2:0] A_STAT  = 3'd3;
  localparam logic [2:0] A_IESET = 3'd4;
  localparam logic [2:0] A_IECLR = 3'd5;
  localparam logic [2:0] A_IEN   = 3'd6;
  localparam logic [2:0] A_CNT   = 3'd7;

  localparam int CMD_RUN  = 0;
  localparam int CMD_STOP = 1;
  localparam int CMD_RST  = 2;

  localparam int MODE_CMP = 0;
  localparam int MODE_EXT = 1;

  localparam int ST_W    = 8;
  localparam int ST_WRAP = 0;
  localparam int ST_HIT  = 4;
  localparam int ST_EXT  = 7;
  localparam logic [ST_W-1:0] ST_VALID =
    ST_W'((1 << ST_WRAP) | (1 << ST_HIT) | (1 << ST_EXT));

  typedef struct packed {
    logic countGo;
    logic restart;
  } tmr_strobe_t;

endpackage

// File: rtl/ivl_timer_dp.sv
module ivl_timer_dp
  import ivl_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmr_strobe_t      strb,
  input  logic [CNT_W-1:0] perVal,
  output logic [CNT_W-1:0] count,
  output logic             wrapEvt,
  output logic             hitEvt,
  output logic             perEq
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] nextCnt;

  always_comb begin
    nextCnt = strb.restart ? '0 : cntQ + CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strb.countGo) begin
      cntQ <= nextCnt;
    end
  end

  assign count   = cntQ;
  assign wrapEvt = strb.countGo && !strb.restart && (cntQ == CNT_MAX);
  assign hitEvt  = strb.countGo && (nextCnt == perVal);
  assign perEq   = (cntQ == perVal);

endmodule

// File: rtl/ivl_timer_ctrl.sv
module ivl_timer_ctrl
  import ivl_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntTick,
  input  logic              syncIn,
  input  logic              extTrigIn,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq,
  input  logic [CNT_W-1:0]  count,
  input  logic              wrapEvt,
  input  logic              hitEvt,
  input  logic              perEq,
  output tmr_strobe_t       strb,
  output logic [CNT_W-1:0]  perVal,
  output logic              clkEnQ,
  output logic [ST_W-1:0]   statusQ,
  output logic [ST_W-1:0]   maskQ
);

  localparam int MODE_W = 2;

  logic [SYNC_STAGES:0] extSh;
  logic                 extRise;
  logic [MODE_W-1:0]    modeQ;
  logic [CNT_W-1:0]     perQ;
  logic                 pendQ;
  logic                 cmdWr, runReq, stopReq, swTrig;
  logic                 effEn, trigNow, extEvt, statRd;
  logic [ST_W-1:0]      setVec;

  // external event: synchronizer chain followed by an edge detector
  always_ff @(posedge clk) begin
    if (!rstN) extSh <= '0;
    else       extSh <= {extSh[SYNC_STAGES-1:0], extTrigIn};
  end
  assign extRise = extSh[SYNC_STAGES-1] && !extSh[SYNC_STAGES];

  assign cmdWr   = regWr && (regAddr == A_CMD);
  assign runReq  = cmdWr && regWdata[CMD_RUN];
  assign stopReq = cmdWr && regWdata[CMD_STOP];
  assign swTrig  = cmdWr && regWdata[CMD_RST];

  // run state as it stands after this cycle's command; stop has priority
  always_comb begin
    if (stopReq)     effEn = 1'b0;
    else if (runReq) effEn = 1'b1;
    else             effEn = clkEnQ;
  end

  assign extEvt  = effEn && modeQ[MODE_EXT] && extRise;
  assign trigNow = effEn && (swTrig || syncIn || extEvt ||
                             (modeQ[MODE_CMP] && perEq));

  assign strb.countGo = clkEnQ && cntTick;
  assign strb.restart = pendQ || trigNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkEnQ <= 1'b0;
      pendQ  <= 1'b0;
    end else begin
      clkEnQ <= effEn;
      if (!effEn || strb.countGo) pendQ <= 1'b0;
      else if (trigNow)           pendQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0;
      perQ  <= '0;
    end else if (regWr) begin
      if (regAddr == A_MODE) modeQ <= regWdata[MODE_W-1:0];
      if (regAddr == A_PER)  perQ  <= regWdata[CNT_W-1:0];
    end
  end
  assign perVal = perQ;

  always_comb begin
    setVec          = '0;
    setVec[ST_WRAP] = wrapEvt;
    setVec[ST_HIT]  = hitEvt;
    setVec[ST_EXT]  = extEvt;
  end

  assign statRd = regRd && (regAddr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
    end else begin
      statusQ <= statRd ? setVec : (statusQ | setVec);
      if (regWr && regAddr == A_IESET)
        maskQ <= maskQ | (regWdata[ST_W-1:0] & ST_VALID);
      else if (regWr && regAddr == A_IECLR)
        maskQ <= maskQ & ~regWdata[ST_W-1:0];
    end
  end

  assign irq = |(statusQ & maskQ);

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_MODE:  regRdata[MODE_W-1:0] = modeQ;
      A_PER:   regRdata[CNT_W-1:0]  = perQ;
      A_STAT:  regRdata[ST_W-1:0]   = statusQ;
      A_IEN:   regRdata[ST_W-1:0]   = maskQ;
      A_CNT:   regRdata[CNT_W-1:0]  = count;
      default: regRdata = '0;
    endcase
  end

endmodule

// File: rtl/ivl_timer_chan.sv
module ivl_timer_chan
  import ivl_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntTick,
  input  logic              syncIn,
  input  logic              extTrigIn,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq
);

  tmr_strobe_t      strb;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] perVal;
  logic             wrapEvt, hitEvt, perEq, clkEnQ;
  logic [ST_W-1:0]  statusQ, maskQ;

  ivl_timer_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W), .SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .syncIn(syncIn),
    .extTrigIn(extTrigIn), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq), .count(count),
    .wrapEvt(wrapEvt), .hitEvt(hitEvt), .perEq(perEq), .strb(strb),
    .perVal(perVal), .clkEnQ(clkEnQ), .statusQ(statusQ), .maskQ(maskQ)
  );

  ivl_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .perVal(perVal), .count(count),
    .wrapEvt(wrapEvt), .hitEvt(hitEvt), .perEq(perEq)
  );

endmodule

// File: rtl/ivl_timer_chk.sv
module ivl_timer_chk
  import ivl_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [CNT_W-1:0]  count,
  input logic              clkEn,
  input logic              countGo,
  input logic              restart,
  input logic [ST_W-1:0]   status,
  input logic [ST_W-1:0]   mask,
  input logic              regWr,
  input logic              regRd,
  input logic [2:0]        regAddr,
  input logic [DATA_W-1:0] regWdata
);

  logic statRd;
  assign statRd = regRd && (regAddr == A_STAT);

  // R1
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> $stable(count));

  // R4
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (countGo && restart) |=> (count == '0));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !countGo |=> $stable(count));

  // R3
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == A_CMD && regWdata[CMD_STOP]) |=> !clkEn);

  // R5
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (countGo && !restart && count == {CNT_W{1'b1}}) |=> status[ST_WRAP]);

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status[ST_HIT] && !statRd) |=> status[ST_HIT]);

  // R8
  ien_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == A_IESET && regWdata[ST_HIT]) |=> mask[ST_HIT]);

endmodule

bind ivl_timer_chan ivl_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .count(count), .clkEn(clkEnQ),
  .countGo(strb.countGo), .restart(strb.restart), .status(statusQ),
  .mask(maskQ), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
  .regWdata(regWdata)
);

// File: tb/ivl_timer_chan_bench.sv
module ivl_timer_chan_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntTick = 1'b0;
  logic        syncIn = 1'b0;
  logic        extTrigIn = 1'b0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [15:0] regWdata = 16'd0;
  logic [15:0] regRdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  logic [15:0] v;

  always #2 clk = ~clk;

  ivl_timer_chan u_ivl_timer_chan (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .syncIn(syncIn),
    .extTrigIn(extTrigIn), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regWdata = 16'd0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    cntTick = 1'b1;
    repeat (n) @(negedge clk);
    cntTick = 1'b0;
  endtask

  task automatic t_reset;
    rd(3'd7, v); chk("R1 count", v, 16'd0);
    rd(3'd3, v); chk("R1 status", v, 16'd0);
    rd(3'd6, v); chk("R1 ien", v, 16'd0);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    ticks(5);
    rd(3'd7, v); chk("R1 stopped", v, 16'd0);
  endtask

  task automatic t_run_stop;
    wr(3'd0, 16'h0001);
    ticks(10);
    rd(3'd7, v); chk("R2 count", v, 16'd10);
    wr(3'd0, 16'h0003);
    ticks(5);
    rd(3'd7, v); chk("R3 stop wins", v, 16'd10);
    wr(3'd0, 16'h0004);
    wr(3'd0, 16'h0001);
    ticks(1);
    rd(3'd7, v); chk("R3 restart ignored while stopped", v, 16'd11);
  endtask

  task automatic t_restart;
    wr(3'd0, 16'h0004);
    rd(3'd7, v); chk("R4 deferred", v, 16'd11);
    ticks(1);
    rd(3'd7, v); chk("R4 sw restart", v, 16'd0);
    ticks(3);
    @(negedge clk) syncIn = 1'b1;
    @(negedge clk) syncIn = 1'b0;
    rd(3'd7, v); chk("R4 sync deferred", v, 16'd3);
    ticks(1);
    rd(3'd7, v); chk("R4 sync restart", v, 16'd0);
  endtask

  task automatic t_compare;
    wr(3'd2, 16'd5);
    wr(3'd1, 16'h0001);
    rd(3'd2, v); chk("R11 period", v, 16'd5);
    rd(3'd1, v); chk("R11 mode", v, 16'd1);
    rd(3'd3, v);
    ticks(5);
    rd(3'd7, v); chk("R6 at C", v, 16'd5);
    rd(3'd3, v); chk("R6 hit flag", v, 16'h0010);
    ticks(1);
    rd(3'd7, v); chk("R6 wrap to 0", v, 16'd0);
    ticks(6);
    rd(3'd7, v); chk("R6 period C+1", v, 16'd0);
    rd(3'd3, v);
    wr(3'd1, 16'h0000);
    ticks(7);
    rd(3'd7, v); chk("R6 no restart when off", v, 16'd7);
    rd(3'd3, v); chk("R6 flag without restart", v, 16'h0010);
  endtask

  task automatic t_wrap;
    wr(3'd0, 16'h0004);
    ticks(1);
    rd(3'd3, v);
    ticks(65535);
    rd(3'd7, v); chk("R5 at max", v, 16'hFFFF);
    rd(3'd3, v); chk("R5 no wrap yet", v, 16'h0010);
    ticks(1);
    rd(3'd7, v); chk("R5 wrapped", v, 16'd0);
    rd(3'd3, v); chk("R5 wrap flag", v, 16'h0001);
  endtask

  task automatic t_ext;
    wr(3'd1, 16'h0002);
    ticks(4);
    @(negedge clk) extTrigIn = 1'b1;
    repeat (4) @(negedge clk);
    rd(3'd3, v); chk("R7 ext flag", v, 16'h0080);
    rd(3'd7, v); chk("R7 deferred", v, 16'd4);
    ticks(1);
    rd(3'd7, v); chk("R7 ext restart", v, 16'd0);
    extTrigIn = 1'b0;
    wr(3'd1, 16'h0000);
    ticks(3);
    @(negedge clk) extTrigIn = 1'b1;
    repeat (4) @(negedge clk);
    rd(3'd3, v); chk("R7 ignored flag", v, 16'd0);
    ticks(1);
    rd(3'd7, v); chk("R7 ignored count", v, 16'd4);
    extTrigIn = 1'b0;
  endtask

  task automatic t_irq;
    wr(3'd4, 16'h0091);
    rd(3'd6, v); chk("R8 set", v, 16'h0091);
    wr(3'd4, 16'hFFFF);
    rd(3'd6, v); chk("R8 valid bits only", v, 16'h0091);
    wr(3'd5, 16'h0010);
    rd(3'd6, v); chk("R8 clear", v, 16'h0081);
    ticks(1);
    @(negedge clk);
    chk("R9 masked", {15'd0, irq}, 16'd0);
    wr(3'd4, 16'h0010);
    chk("R9 enabled", {15'd0, irq}, 16'd1);
    rd(3'd3, v); chk("R10 read value", v, 16'h0010);
    chk("R10 cleared irq", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_read_race;
    wr(3'd0, 16'h0004);
    ticks(1);
    ticks(4);
    rd(3'd3, v);
    @(negedge clk);
    regRd = 1'b1; regAddr = 3'd3; cntTick = 1'b1;
    #1 v = regRdata;
    chk("R10 same-cycle read value", v, 16'd0);
    @(negedge clk);
    regRd = 1'b0; cntTick = 1'b0;
    chk("R10 irq kept", {15'd0, irq}, 16'd1);
    rd(3'd3, v); chk("R10 flag kept", v, 16'h0010);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset;
    t_run_stop;
    t_restart;
    t_compare;
    t_wrap;
    t_ext;
    t_irq;
    t_read_race;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule